// File: doc/BRIEF.md
# Swarm Particle Coordinate Updater

This block performs the arithmetic of one particle swarm search iteration for a single particle whose state is a set of cell coordinates on a square grid of logic cells. Each coordinate is one dimension. The new velocity is built from three parts: an inertia part proportional to the old velocity, and two attraction parts. One attraction part points toward the particle's own best coordinate and the other toward the swarm's best coordinate. Each attraction part is scaled by a configured gain and by a fresh random factor. The velocity is then limited in magnitude, added to the old coordinate, rounded to a whole cell index and kept on the grid.

A single start pulse sweeps every dimension of the particle in index order, one dimension per clock. The block presents the dimension index it is reading on `rd_idx`. The surrounding logic returns that dimension's coordinate, velocity, personal best and global best in the same cycle, as an asynchronous-read memory would. Results leave the block one cycle later on a write strobe with their index. A one-cycle `done` pulse follows the final write. Random factors come from an internal 16-bit linear feedback shift register that the user can reseed. Fitness evaluation and best tracking live outside this block.

All quantities are fixed point. Gains and random factors are unsigned with 7 fraction bits. Velocities are two's complement with 4 fraction bits. Coordinates are unsigned integers from 0 to GRID-1.

Top module: `pso_particle_update`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy`, `wr_en` and `done` are 0 and `rd_idx` is 0.
- R2: After `start` is sampled high while idle, the block writes exactly 2*NCELL results, one per cycle, with `wr_idx` running 0, 1, 2 and so on. The first write appears on the cycle after the sampling edge. The result for index k is computed from the inputs presented while `rd_idx` equals k.
- R3: The new velocity code equals floor((W·v·8 + C1·r1·(pb−p) + C2·r2·(gb−p)) / 1024) before limiting. W, C1 and C2 are the raw 8-bit gain codes. v is the raw velocity code (1/16 units). r1 and r2 are the raw 7-bit random codes. p, pb and gb are the integer coordinate, personal best and global best.
- R4: The new velocity is limited to the range −`vmax` to +`vmax`, where `vmax` is a code in 1/16 units.
- R5: The new coordinate is floor(p + v_new/16 + 1/2), that is, p plus the limited velocity rounded to the nearest cell with halves rounding up. It is then saturated to 0 to GRID−1.
- R6: The random source is a 16-bit register that resets to 0xACE1. One advance shifts the register left by one bit and sets bit 0 to the XOR of bits 15, 13, 12 and 10. Each dimension advances the register twice. r1 is bits 6:0 after the first advance and r2 is bits 6:0 after the second. The register does not advance while idle.
- R7: A pulse on `seed_load` while idle copies `seed` into the random register, except that a zero seed is ignored and the register keeps its state.
- R8: `done` is high for exactly one cycle, the cycle after the last write.
- R9: A `start` pulse while a sweep is in progress is ignored: no extra writes occur and the sweep is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sweep over all dimensions |
| seed_load | input | 1 | Load `seed` into the random register (idle only) |
| seed | input | 16 | Random register seed, zero ignored |
| w_inertia | input | CW | Inertia weight, unsigned, 7 fraction bits |
| c_cog | input | CW | Personal-best gain, unsigned, 7 fraction bits |
| c_soc | input | CW | Global-best gain, unsigned, 7 fraction bits |
| vmax | input | VW-1 | Velocity magnitude limit, 4 fraction bits |
| busy | output | 1 | Sweep in progress |
| rd_idx | output | IW | Dimension whose inputs are being read |
| cur_pos | input | PW | Coordinate of dimension `rd_idx` |
| cur_vel | input | VW | Signed velocity of dimension `rd_idx` |
| pers_best | input | PW | Personal best coordinate of dimension `rd_idx` |
| glob_best | input | PW | Global best coordinate of dimension `rd_idx` |
| wr_en | output | 1 | Result valid strobe |
| wr_idx | output | IW | Dimension of the result |
| new_vel | output | VW | Updated signed velocity |
| new_pos | output | PW | Updated coordinate |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
On every cycle, the assertions check that written coordinates stay on the grid and that written velocities lie within the limit. They also check that write indices rise by one from zero, that `done` is a single-cycle pulse directly after the last index, and that the random register never reaches zero. Only the bench scenarios can show that the velocity and coordinate values themselves are correct. Those values depend on the random sequence, the rounding direction, the gain scaling and the effect of reseeding with zero, which the bench checks against its own model of the update rule. The bench also covers a restart pulse during a sweep, which it observes through the count and timing of writes.

// File: rtl/pso_particle_update.sv
module pso_particle_update #(
  parameter int GRID = 14,
  parameter int NCELL = 7,
  parameter int CW = 8,
  parameter int VW = 10,
  parameter int VFRAC = 4,
  parameter logic [15:0] SEED_RST = 16'hACE1,
  localparam int NDIM = 2 * NCELL,
  localparam int PW = $clog2(GRID),
  localparam int IW = $clog2(NDIM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 seed_load,
  input  logic [15:0]          seed,
  input  logic [CW-1:0]        w_inertia,
  input  logic [CW-1:0]        c_cog,
  input  logic [CW-1:0]        c_soc,
  input  logic [VW-2:0]        vmax,
  output logic                 busy,
  output logic [IW-1:0]        rd_idx,
  input  logic [PW-1:0]        cur_pos,
  input  logic signed [VW-1:0] cur_vel,
  input  logic [PW-1:0]        pers_best,
  input  logic [PW-1:0]        glob_best,
  output logic                 wr_en,
  output logic [IW-1:0]        wr_idx,
  output logic signed [VW-1:0] new_vel,
  output logic [PW-1:0]        new_pos,
  output logic                 done
);
  localparam int CFRAC = CW - 1;
  localparam int SW = 2 * CW + VW + PW + 2;
  localparam int WSH = CFRAC - VFRAC;
  localparam int RSH = 2 * CFRAC - VFRAC;
  localparam logic [IW-1:0] LAST = IW'(NDIM - 1);
  localparam logic signed [SW-1:0] GMAX = SW'(GRID - 1);
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (VFRAC - 1));

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  logic [15:0] lfsr, rs1, rs2;
  logic [IW-1:0] idx;
  logic signed [SW-1:0] w_x, c1_x, c2_x, r1_x, r2_x, v_x, p_x, pb_x, gb_x;
  logic signed [SW-1:0] t0, t1, t2, vs, vlim, vc, pfix, prnd;
  logic [PW-1:0] pos_sat;

  assign rs1 = lfsr_next(lfsr);
  assign rs2 = lfsr_next(rs1);
  assign rd_idx = idx;

  assign w_x  = signed'(SW'(w_inertia));
  assign c1_x = signed'(SW'(c_cog));
  assign c2_x = signed'(SW'(c_soc));
  assign r1_x = signed'(SW'(rs1[CW-2:0]));
  assign r2_x = signed'(SW'(rs2[CW-2:0]));
  assign v_x  = SW'(cur_vel);
  assign p_x  = signed'(SW'(cur_pos));
  assign pb_x = signed'(SW'(pers_best));
  assign gb_x = signed'(SW'(glob_best));

  assign t0 = (w_x * v_x) <<< WSH;
  assign t1 = c1_x * r1_x * (pb_x - p_x);
  assign t2 = c2_x * r2_x * (gb_x - p_x);
  assign vs = (t0 + t1 + t2) >>> RSH;

  assign vlim = signed'(SW'(vmax));
  assign vc = (vs > vlim) ? vlim : ((vs < -vlim) ? -vlim : vs);

  assign pfix = (p_x <<< VFRAC) + vc;
  assign prnd = (pfix + HALF) >>> VFRAC;
  assign pos_sat = (prnd < 0) ? '0 : ((prnd > GMAX) ? GMAX[PW-1:0] : prnd[PW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      new_vel <= '0;
      new_pos <= '0;
      done    <= 1'b0;
      lfsr    <= SEED_RST;
    end else begin
      wr_en <= busy;
      done  <= wr_en && (wr_idx == LAST);
      if (busy) begin
        wr_idx  <= idx;
        new_vel <= vc[VW-1:0];
        new_pos <= pos_sat;
        lfsr    <= rs2;
        if (idx == LAST) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (seed_load && (seed != 16'h0)) begin
        lfsr <= seed;
      end
    end
  end
endmodule

// File: rtl/pso_update_chk.sv
module pso_update_chk #(
  parameter int GRID = 14,
  parameter int NDIM = 14,
  parameter int VW = 10,
  parameter int PW = 4,
  parameter int IW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [IW-1:0]        wr_idx,
  input logic signed [VW-1:0] new_vel,
  input logic [PW-1:0]        new_pos,
  input logic                 done,
  input logic [VW-2:0]        vmax,
  input logic [15:0]          lfsr
);
  // R5
  pos_in_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (new_pos <= PW'(GRID - 1)));

  // R4
  vel_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (($signed(new_vel) <= $signed({1'b0, $past(vmax)})) &&
               ($signed(new_vel) >= -$signed({1'b0, $past(vmax)}))));

  // R2
  first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> (wr_idx == '0));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx == IW'($past(wr_idx) + 1'b1)));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wr_en) && ($past(wr_idx) == IW'(NDIM - 1))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);
endmodule

bind pso_particle_update pso_update_chk #(
  .GRID(GRID), .NDIM(NDIM), .VW(VW), .PW(PW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .new_vel(new_vel), .new_pos(new_pos), .done(done), .vmax(vmax), .lfsr(lfsr)
);

// File: tb/tb_pso_particle_update.sv
`timescale 1ns/1ps
module tb_pso_particle_update;
  localparam int GRID = 14;
  localparam int NDIM = 14;
  localparam int VW = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, seed_load, busy, wr_en, done;
  logic [15:0] seed;
  logic [7:0] w_inertia, c_cog, c_soc;
  logic [VW-2:0] vmax;
  logic [3:0] rd_idx, wr_idx, cur_pos, pers_best, glob_best, new_pos;
  logic signed [VW-1:0] cur_vel, new_vel;

  int pos_m[NDIM], vel_m[NDIM], pb_m[NDIM], gb_m[NDIM], pos_n[NDIM], vel_n[NDIM];
  assign cur_pos   = 4'(pos_m[rd_idx]);
  assign cur_vel   = VW'(vel_m[rd_idx]);
  assign pers_best = 4'(pb_m[rd_idx]);
  assign glob_best = 4'(gb_m[rd_idx]);

  pso_particle_update dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed(seed),
    .w_inertia(w_inertia), .c_cog(c_cog), .c_soc(c_soc), .vmax(vmax),
    .busy(busy), .rd_idx(rd_idx), .cur_pos(cur_pos), .cur_vel(cur_vel),
    .pers_best(pers_best), .glob_best(glob_best), .wr_en(wr_en), .wr_idx(wr_idx),
    .new_vel(new_vel), .new_pos(new_pos), .done(done)
  );

  int tests = 0, fails = 0;
  logic [15:0] model;
  int q_idx[$], q_vel[$], q_pos[$];
  string q_tag[$];

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int fdiv(int a, int b);
    return (a >= 0) ? a / b : -((-a + b - 1) / b);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (q_idx.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 unexpected write actual=idx%0d expected=none", wr_idx);
      end else begin
        int ei, ev, ep;
        string et;
        ei = q_idx.pop_front(); ev = q_vel.pop_front();
        ep = q_pos.pop_front(); et = q_tag.pop_front();
        chk("R2 write index", int'(wr_idx), ei);
        chk({et, " velocity"}, int'(new_vel), ev);
        chk({et, " R5 position"}, int'(new_pos), ep);
      end
    end
  end

  task automatic load_seed(logic [15:0] s);
    @(negedge clk); seed = s; seed_load = 1'b1;
    @(negedge clk); seed_load = 1'b0;
    if (s != 16'h0) model = s;  // R7: zero leaves model unchanged
  endtask

  task automatic run_iter(int w, int a, int b, int vm, bit restart, string note);
    int n;
    w_inertia = 8'(w); c_cog = 8'(a); c_soc = 8'(b); vmax = 9'(vm);
    for (int d = 0; d < NDIM; d++) begin
      int ra, rb, num, v, p;
      string tag;
      model = nxt(model); ra = int'(model[6:0]);   // R6
      model = nxt(model); rb = int'(model[6:0]);
      num = w * vel_m[d] * 8 + a * ra * (pb_m[d] - pos_m[d]) + b * rb * (gb_m[d] - pos_m[d]);
      v = fdiv(num, 1024);  // R3
      tag = {note, " R3 R6"};
      if (v > vm) begin v = vm; tag = {note, " R4"}; end
      if (v < -vm) begin v = -vm; tag = {note, " R4"}; end
      p = fdiv(pos_m[d] * 16 + v + 8, 16);
      if (p < 0) p = 0;
      if (p > GRID - 1) p = GRID - 1;
      q_idx.push_back(d); q_vel.push_back(v); q_pos.push_back(p); q_tag.push_back(tag);
      vel_n[d] = v; pos_n[d] = p;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk); n++;
      if (restart && n == 3) start = 1'b1;  // R9
      if (restart && n == 4) start = 1'b0;
    end
    chk({note, " R8 done timing"}, n, NDIM + 1);
    chk({note, " R2 all dimensions written"}, q_idx.size(), 0);
    @(negedge clk);
    chk({note, " R8 done single cycle"}, int'(done), 0);
    repeat (4) @(negedge clk);
    chk({note, " R9 no trailing writes"}, int'(busy), 0);
    for (int d = 0; d < NDIM; d++) begin
      vel_m[d] = vel_n[d]; pos_m[d] = pos_n[d];
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; seed_load = 1'b0; seed = '0;
    w_inertia = '0; c_cog = '0; c_soc = '0; vmax = '0;
    for (int d = 0; d < NDIM; d++) begin
      pos_m[d] = (d * 5) % GRID;
      vel_m[d] = ((d * 37) % 200) - 100;
      pb_m[d] = (d * 3 + 1) % GRID;
      gb_m[d] = 13 - d % GRID;
    end
    model = 16'hACE1;  // R6 reset seed
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rd_idx", int'(rd_idx), 0);

    run_iter(8'h60, 8'h80, 8'h80, 9'h1FF, 1'b0, "base");
    repeat (5) @(negedge clk);
    run_iter(8'h50, 8'hA0, 8'h40, 9'h1FF, 1'b0, "idle-gap");

    load_seed(16'h1234);
    run_iter(8'hFF, 8'hFF, 8'hFF, 9'h010, 1'b0, "small-vmax");

    load_seed(16'h0000);
    run_iter(8'h40, 8'h20, 8'hC0, 9'h0C8, 1'b1, "R7 zero-seed R9 restart");

    for (int d = 0; d < NDIM; d++) begin
      if (d % 2 == 0) begin pos_m[d] = 13; vel_m[d] = 300;  pb_m[d] = 13; gb_m[d] = 13; end
      else            begin pos_m[d] = 0;  vel_m[d] = -300; pb_m[d] = 0;  gb_m[d] = 0;  end
    end
    run_iter(8'hFF, 8'h00, 8'h00, 9'h1FF, 1'b0, "edge-saturation");

    for (int d = 0; d < NDIM; d++) begin
      pos_m[d] = d % GRID; vel_m[d] = 7 - d; pb_m[d] = 13 - d % GRID; gb_m[d] = 6;
    end
    run_iter(8'h80, 8'h00, 8'h00, 9'h1FF, 1'b0, "rounding");
    run_iter(8'h00, 8'h00, 8'h00, 9'h1FF, 1'b0, "zero-gains");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule